// File: doc/BRIEF.md
# Sv39 page table walker

This block turns a virtual address into a physical address by walking three-level Sv39 page tables held in memory. A walk starts with a one-cycle start pulse. The pulse carries the virtual address, the current address-translation control word (SATP) and the current privilege mode. The walker then fetches one 64-bit page table entry (PTE) per level through a ready/valid read port. It finishes with a one-cycle done pulse that carries either the physical address or a fault flag.

When translation is switched off, or the hart runs in machine mode, the walker reads no memory. It passes the low 56 bits of the virtual address straight through. When translation is on, the walk starts at level 2 and descends until it finds a leaf. A leaf found at level 2 yields a gigapage, at level 1 a megapage, and at level 0 a kilopage. The walker accepts a new walk only after the previous one has finished.

Top module: `pgwalk_top`

## Requirements
- R1: When bit 63 of the control word is 0, a start seen while idle gives done in the following cycle, with fault low, the physical address equal to the virtual address bits 55:0, and no read request.
- R2: When the privilege mode is 2'b11 (machine), translation is bypassed exactly as in R1, even with bit 63 of the control word set.
- R3: The first read goes to the word address ((ctl[43:0] << 12) + VA[38:30]*8) >> 3.
- R4: The level indices are VA[38:30] (level 2), VA[29:21] (level 1) and VA[20:12] (level 0). The page offset is VA[11:0]. VA bits 63:39 have no effect on the walk.
- R5: A PTE with bit 0 (valid) set is a leaf when bit 1 (read) or bit 3 (execute) is set. Any other valid PTE, including one with only bit 2 (write) set, points to a next table whose base is PTE[53:10] << 12, and the walk reads the entry at the next lower level.
- R6: A leaf at level 2 gives the physical address {PTE[53:28], VA[29:12], VA[11:0]}.
- R7: A leaf at level 1 gives the physical address {PTE[53:19], VA[20:12], VA[11:0]}.
- R8: A leaf at level 0 gives the physical address {PTE[53:10], VA[11:0]}.
- R9: A PTE with bit 0 clear ends the walk with done and fault high and a physical address of 0. Fault is never high outside the done cycle.
- R10: A valid non-leaf PTE read at level 0 ends the walk with done and fault high.
- R11: A read request stays raised with a stable address until ready is seen. Only one read is outstanding at a time. Done rises in the cycle after the final response and lasts exactly one cycle.
- R12: A start pulse while a walk is in progress is ignored. The walk completes with the address latched at its own start, and no extra walk follows.
- R13: A synchronous active-high reset, even in the middle of a walk, returns the walker to idle with done, fault and the read request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a walk (taken only when idle) |
| vaddr_i | input | 64 | Virtual address to translate |
| satp_i | input | 64 | Translation control word: bit 63 enables translation, bits 43:0 give the root table page number |
| priv_i | input | 2 | Current privilege mode; 2'b11 is machine mode |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 53 | Word address of the requested PTE |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Read data (one PTE) |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk faulted; valid during done |
| paddr_o | output | 56 | Translated physical address; valid during done |

## Verification
The bench builds the walker with its default parameters: a 64-bit virtual address, 9-bit table indices, a 12-bit offset and three levels. These give Sv39 geometry, so a single sparse page table in the bench reaches all three leaf sizes, both fault kinds and a write-only pointer entry. Ready and response delays are set per walk, from zero to several cycles. This exposes the request-hold and single-outstanding rules, and opens a window in which a start pulse during a walk and a reset in the middle of a walk can be driven.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_REQ,
        WS_WAIT,
        WS_DONE
    } walk_state_e;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    localparam int PTE_V_BIT = 0;
    localparam int PTE_R_BIT = 1;
    localparam int PTE_X_BIT = 3;

endpackage

// File: rtl/pgwalk_index.sv
module pgwalk_index #(
    parameter int PA_W   = 56,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2
) (
    input  logic [PA_W-1:0]  vaddr_i,
    input  logic [LVL_W-1:0] level_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [IDX_W-1:0] fld [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_field
        assign fld[g] = vaddr_i[OFF_W + g*IDX_W +: IDX_W];
    end

    always_comb begin
        idx_o = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level_i == LVL_W'(l)) begin
                idx_o = fld[l];
            end
        end
    end

endmodule

// File: rtl/pgwalk_pte_chk.sv
module pgwalk_pte_chk #(
    parameter int PTE_W  = 64,
    parameter int PPN_LO = 10,
    parameter int PPN_W  = 44
) (
    input  logic [PTE_W-1:0] pte_i,
    output logic             valid_o,
    output logic             leaf_o,
    output logic [PPN_W-1:0] ppn_o
);
    import pgwalk_pkg::*;

    logic unused_pte;

    assign valid_o    = pte_i[PTE_V_BIT];
    assign leaf_o     = pte_i[PTE_R_BIT] | pte_i[PTE_X_BIT];
    assign ppn_o      = pte_i[PPN_LO +: PPN_W];
    assign unused_pte = ^pte_i;

endmodule

// File: rtl/pgwalk_compose.sv
module pgwalk_compose #(
    parameter int PA_W   = 56,
    parameter int PPN_W  = 44,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2
) (
    input  logic [PA_W-1:0]  vaddr_i,
    input  logic [PPN_W-1:0] ppn_i,
    input  logic [LVL_W-1:0] level_i,
    output logic [PA_W-1:0]  paddr_o
);

    logic [PA_W-1:0] cand [LEVELS];
    logic [PA_W-1:0] frame;

    assign frame = PA_W'({ppn_i, {OFF_W{1'b0}}});

    for (genvar g = 0; g < LEVELS; g++) begin : g_size
        localparam logic [PA_W-1:0] KEEP_VA = (PA_W'(1) << (OFF_W + g*IDX_W)) - PA_W'(1);
        assign cand[g] = (frame & ~KEEP_VA) | (vaddr_i & KEEP_VA);
    end

    always_comb begin
        paddr_o = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (level_i == LVL_W'(l)) begin
                paddr_o = cand[l];
            end
        end
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PA_W     = 56,
    parameter int PTE_W    = 64,
    parameter int SATP_W   = 64,
    parameter int IDX_W    = 9,
    parameter int OFF_W    = 12,
    parameter int LEVELS   = 3,
    parameter int PPN_LO   = 10,
    parameter int PPN_W    = 44,
    parameter int ROOT_W   = 44,
    parameter int MODE_BIT = 63,
    localparam int WORD_SH = $clog2(PTE_W / 8),
    localparam int MADR_W  = PA_W - WORD_SH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [VA_W-1:0]   vaddr_i,
    input  logic [SATP_W-1:0] satp_i,
    input  logic [1:0]        priv_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [MADR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [PTE_W-1:0]  mem_rsp_data_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [PA_W-1:0]   paddr_o
);

    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    typedef struct packed {
        walk_state_e      state;
        logic [LVL_W-1:0] level;
        logic [PA_W-1:0]  base;
        logic [PA_W-1:0]  vaddr;
        logic [PA_W-1:0]  paddr;
        logic             fault;
    } walk_regs_t;

    localparam walk_regs_t REGS_RST = '0;

    walk_regs_t r_d, r_q;

    logic [IDX_W-1:0] idx;
    logic             pte_valid;
    logic             pte_leaf;
    logic [PPN_W-1:0] pte_ppn;
    logic [PA_W-1:0]  leaf_paddr;
    logic [PA_W-1:0]  req_byte;
    logic             xlate_on;
    logic             walk_idle;
    logic             unused_in;

    assign xlate_on  = satp_i[MODE_BIT] && (priv_i != PRIV_MACHINE);
    assign walk_idle = (r_q.state == WS_IDLE);
    assign unused_in = ^{vaddr_i, satp_i, req_byte[WORD_SH-1:0]};

    pgwalk_index #(
        .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_index (
        .vaddr_i(r_q.vaddr),
        .level_i(r_q.level),
        .idx_o  (idx)
    );

    pgwalk_pte_chk #(
        .PTE_W(PTE_W), .PPN_LO(PPN_LO), .PPN_W(PPN_W)
    ) u_pte (
        .pte_i  (mem_rsp_data_i),
        .valid_o(pte_valid),
        .leaf_o (pte_leaf),
        .ppn_o  (pte_ppn)
    );

    pgwalk_compose #(
        .PA_W(PA_W), .PPN_W(PPN_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
        .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_compose (
        .vaddr_i(r_q.vaddr),
        .ppn_i  (pte_ppn),
        .level_i(r_q.level),
        .paddr_o(leaf_paddr)
    );

    assign req_byte = r_q.base + (PA_W'(idx) << WORD_SH);

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            WS_IDLE: begin
                if (start_i) begin
                    r_d.vaddr = vaddr_i[PA_W-1:0];
                    r_d.fault = 1'b0;
                    if (xlate_on) begin
                        r_d.level = LVL_W'(LEVELS - 1);
                        r_d.base  = PA_W'(satp_i[ROOT_W-1:0]) << OFF_W;
                        r_d.state = WS_REQ;
                    end else begin
                        r_d.paddr = vaddr_i[PA_W-1:0];
                        r_d.state = WS_DONE;
                    end
                end
            end
            WS_REQ: begin
                if (mem_req_ready_i) begin
                    r_d.state = WS_WAIT;
                end
            end
            WS_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (!pte_valid) begin
                        r_d.fault = 1'b1;
                        r_d.paddr = '0;
                        r_d.state = WS_DONE;
                    end else if (pte_leaf) begin
                        r_d.paddr = leaf_paddr;
                        r_d.state = WS_DONE;
                    end else if (r_q.level == '0) begin
                        r_d.fault = 1'b1;
                        r_d.paddr = '0;
                        r_d.state = WS_DONE;
                    end else begin
                        r_d.level = r_q.level - LVL_W'(1);
                        r_d.base  = PA_W'({pte_ppn, {OFF_W{1'b0}}});
                        r_d.state = WS_REQ;
                    end
                end
            end
            WS_DONE: begin
                r_d.fault = 1'b0;
                r_d.state = WS_IDLE;
            end
            default: r_d.state = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_valid_o = (r_q.state == WS_REQ);
    assign mem_req_addr_o  = req_byte[PA_W-1:WORD_SH];
    assign done_o          = (r_q.state == WS_DONE);
    assign fault_o         = done_o && r_q.fault;
    assign paddr_o         = r_q.paddr;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
    parameter int PA_W     = 56,
    parameter int MADR_W   = 53,
    parameter int SATP_W   = 64,
    parameter int MODE_BIT = 63
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [SATP_W-1:0] satp_i,
    input logic [1:0]        priv_i,
    input logic [PA_W-1:0]   vaddr_low,
    input logic              idle,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic [MADR_W-1:0] mem_req_addr_o,
    input logic              done_o,
    input logic              fault_o,
    input logic [PA_W-1:0]   paddr_o
);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R11
    done_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_req_valid_o);

    // R9
    fault_in_done_chk: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> done_o);

    // R1
    bypass_chk: assert property (@(posedge clk) disable iff (rst)
        start_i && idle && (!satp_i[MODE_BIT] || priv_i == 2'b11)
        |=> done_o && !fault_o && !mem_req_valid_o && paddr_o == $past(vaddr_low));

endmodule

bind pgwalk_top pgwalk_chk #(
    .PA_W(PA_W), .MADR_W(MADR_W), .SATP_W(SATP_W), .MODE_BIT(MODE_BIT)
) u_pgwalk_chk (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .satp_i         (satp_i),
    .priv_i         (priv_i),
    .vaddr_low      (vaddr_i[PA_W-1:0]),
    .idle           (walk_idle),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o (mem_req_addr_o),
    .done_o         (done_o),
    .fault_o        (fault_o),
    .paddr_o        (paddr_o)
);

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] vaddr = '0;
    logic [63:0] satp = '0;
    logic [1:0]  priv = 2'b01;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [52:0] req_addr;
    logic        rsp_valid = 1'b0;
    logic [63:0] rsp_data = '0;
    logic        done;
    logic        fault;
    logic [55:0] paddr;

    int checks = 0;
    int errors = 0;

    logic [63:0] mem [longint];

    always #4 clk = ~clk;

    pgwalk_top i_pgwalk_top (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start),
        .vaddr_i        (vaddr),
        .satp_i         (satp),
        .priv_i         (priv),
        .mem_req_valid_o(req_valid),
        .mem_req_ready_i(req_ready),
        .mem_req_addr_o (req_addr),
        .mem_rsp_valid_i(rsp_valid),
        .mem_rsp_data_i (rsp_data),
        .done_o         (done),
        .fault_o        (fault),
        .paddr_o        (paddr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_rd(input longint w);
        return mem.exists(w) ? mem[w] : 64'h0;
    endfunction

    function automatic logic [63:0] mkva(input int v2, input int v1, input int v0,
                                         input int off, input logic [24:0] hi);
        return ({39'h0, hi} << 39) | (64'(v2) << 30) | (64'(v1) << 21) |
               (64'(v0) << 12) | 64'(off);
    endfunction

    // Behavioural reference: walk the bench memory
    task automatic ref_walk(input logic [63:0] va, input logic [63:0] st, input logic [1:0] pv,
                            output logic [55:0] pa, output bit flt, output longint q[$]);
        logic [63:0] base, vpn, w, pte, msk, frame;
        q = {};
        flt = 1'b0;
        pa = '0;
        if (!st[63] || pv == 2'b11) begin
            pa = va[55:0];
            return;
        end
        base = {20'h0, st[43:0]} << 12;
        for (int lv = 2; lv >= 0; lv--) begin
            vpn = (va >> (12 + 9*lv)) & 64'h1FF;
            w = (base + vpn * 8) >> 3;
            q.push_back(longint'(w));
            pte = mem_rd(longint'(w));
            if (!pte[0]) begin
                flt = 1'b1;
                return;
            end
            if (pte[1] || pte[3]) begin
                msk = (64'd1 << (12 + 9*lv)) - 64'd1;
                frame = {20'h0, pte[53:10]} << 12;
                pa = 56'((frame & ~msk) | (va & msk));
                return;
            end
            base = {20'h0, pte[53:10]} << 12;
        end
        flt = 1'b1;
    endtask

    task automatic run_walk(input string tag, input logic [63:0] va, input logic [63:0] st,
                            input logic [1:0] pv, input int rdy_dly, input int rsp_dly,
                            input bit poke);
        logic [55:0] exp_pa;
        bit exp_f;
        longint q[$];
        ref_walk(va, st, pv, exp_pa, exp_f, q);
        @(negedge clk);
        start = 1'b1; vaddr = va; satp = st; priv = pv;
        @(negedge clk);
        start = 1'b0; vaddr = '0;
        foreach (q[k]) begin
            for (int d = 0; d <= rdy_dly; d++) begin
                check(req_valid === 1'b1, "R11", "request held", 64'(req_valid), 64'd1);
                check(req_addr === q[k][52:0], tag, "PTE word address",
                      64'(req_addr), 64'(q[k]));
                check(done === 1'b0, "R11", "done during request", 64'(done), 64'd0);
                if (d == rdy_dly) req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
            end
            for (int d = 0; d < rsp_dly; d++) begin
                check(req_valid === 1'b0 && done === 1'b0, "R11", "second request while waiting",
                      64'({req_valid, done}), 64'd0);
                if (poke && d == 0) begin
                    start = 1'b1; vaddr = ~va;
                end
                @(negedge clk);
                start = 1'b0; vaddr = '0;
            end
            rsp_valid = 1'b1;
            rsp_data = mem_rd(q[k]);
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_data = '0;
        end
        check(done === 1'b1, tag, "done after last response", 64'(done), 64'd1);
        check(fault === exp_f, tag, "fault", 64'(fault), 64'(exp_f));
        check(paddr === exp_pa, tag, "physical address", 64'(paddr), 64'(exp_pa));
        @(negedge clk);
        check(done === 1'b0 && req_valid === 1'b0, "R12", "idle after done",
              64'({done, req_valid}), 64'd0);
    endtask

    localparam logic [63:0] SATP_ON = 64'h8000_0000_0008_0000;
    localparam longint ROOT = 64'h1000_0000;
    localparam longint TBL1 = 64'h80001 * 512;
    localparam longint TBL2 = 64'h80002 * 512;

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mem[ROOT + 1] = (64'h80001 << 10) | 64'h1;
        mem[ROOT + 3] = (64'h80001 << 10) | 64'h5;
        mem[ROOT + 7] = (64'hABCDE123 << 10) | 64'h3;
        mem[TBL1 + 2] = (64'h80002 << 10) | 64'h1;
        mem[TBL1 + 5] = (64'hF0F0F0F1 << 10) | 64'h9;
        mem[TBL2 + 3] = (64'h12345 << 10) | 64'h7;
        mem[TBL2 + 4] = (64'h80003 << 10) | 64'h1;
        mem[TBL2 + 6] = (64'h55555 << 10) | 64'h8;

        // R13 reset state
        @(negedge clk);
        check(done === 1'b0 && fault === 1'b0 && req_valid === 1'b0, "R13", "reset outputs",
              64'({done, fault, req_valid}), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1 mode bit clear
        run_walk("R1", 64'hFFFF_1234_5678_9ABC, 64'h0000_0000_0008_0000, 2'b01, 0, 0, 1'b0);
        // R2 machine mode
        run_walk("R2", mkva(1, 2, 3, 12'h456, 25'h0), SATP_ON, 2'b11, 0, 0, 1'b0);
        // R3 / R8 kilopage, no delay
        run_walk("R3/R8", mkva(1, 2, 3, 12'h456, 25'h0), SATP_ON, 2'b01, 0, 0, 1'b0);
        // R4 / R12 high bits set, delays, start poked mid walk
        run_walk("R4/R12", mkva(1, 2, 3, 12'hABC, 25'h1AB_CDEF), SATP_ON, 2'b01, 2, 3, 1'b1);
        // R7 megapage, low PPN bits replaced
        run_walk("R7", mkva(1, 5, 9'h1AB, 12'h7FF, 25'h0), SATP_ON, 2'b01, 1, 1, 1'b0);
        // R6 gigapage
        run_walk("R6", mkva(7, 9'h155, 9'h0AA, 12'h123, 25'h0), SATP_ON, 2'b00, 0, 2, 1'b0);
        // R9 invalid at level 2
        run_walk("R9", mkva(9, 1, 1, 12'h0, 25'h0), SATP_ON, 2'b01, 0, 0, 1'b0);
        // R9 invalid leaf at level 0
        run_walk("R9", mkva(1, 2, 6, 12'h10, 25'h0), SATP_ON, 2'b01, 1, 0, 1'b0);
        // R10 pointer at level 0
        run_walk("R10", mkva(1, 2, 4, 12'h20, 25'h0), SATP_ON, 2'b01, 0, 1, 1'b0);
        // R5 write-only entry is a pointer
        run_walk("R5", mkva(3, 2, 3, 12'h321, 25'h0), SATP_ON, 2'b00, 0, 0, 1'b0);

        // R13 reset in the middle of a walk
        @(negedge clk);
        start = 1'b1; vaddr = mkva(1, 2, 3, 0, 0); satp = SATP_ON; priv = 2'b01;
        @(negedge clk);
        start = 1'b0;
        check(req_valid === 1'b1, "R13", "walk started before reset", 64'(req_valid), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        check(done === 1'b0 && fault === 1'b0 && req_valid === 1'b0, "R13", "mid-walk reset",
              64'({done, fault, req_valid}), 64'd0);
        rst = 1'b0;
        run_walk("R13", mkva(1, 2, 3, 12'h001, 25'h0), SATP_ON, 2'b01, 0, 0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule